// File: doc/BRIEF.md
# Trap Entry and Return Stage

This block is the combinational execute step of a 64-bit processor's trap unit. It handles two micro-operations. The first is system-call entry: control is sent to a fixed vector, the return address is saved, and a masked copy of the machine state word is saved. The second is return-from-interrupt: control goes back to the saved address, and the machine state word is rebuilt bit by bit from the saved copy, under a few privilege rules.

Each result comes out with its own valid flag, so a later writeback step commits only the registers that the operation changes. A context tag from the issue side passes through unchanged, so that results can be matched to their requests. The machine state word uses LSB-0 numbering. The bits that have special behaviour are: hypervisor at 60, external-interrupt enable at 15, problem state at 14, machine-check enable at 12, instruction relocate at 5 and data relocate at 4.

Top module: `trap_stage`

## Requirements
- R1: When `op_kind` is 2'b01 (system call), `next_pc` equals 64'hC00 and `next_pc_vld` is 1.
- R2: On a system call, `srr_pc_out` equals `cur_pc + 4`, taken modulo 2^64, and `srr_pc_vld` is 1.
- R3: On a system call, `srr_msr_out` equals `cur_msr` with bits 16 to 21 and bits 27 to 30 forced to 0. Every other bit is copied unchanged, and `srr_msr_vld` is 1.
- R4: On a system call, `msr_vld` is 0 and `msr_out` is 0.
- R5: When `op_kind` is 2'b10 (return from interrupt), `next_pc` equals `srr_pc_in` with bits 1:0 cleared. `next_pc_vld` and `msr_vld` are 1. `srr_pc_vld` and `srr_msr_vld` are 0, and both save outputs are 0.
- R6: On a return, `msr_out[60]` equals `srr_msr_in[60] & cur_msr[60]`.
- R7: On a return, each of `msr_out[15]`, `msr_out[5]` and `msr_out[4]` equals the same bit of `srr_msr_in` ORed with `srr_msr_in[14]`.
- R8: On a return, `msr_out[12]` equals `srr_msr_in[12]` when `cur_msr[60]` is 1. Otherwise it equals `cur_msr[12]`.
- R9: On a return, every `msr_out` bit not named in R6 to R8 equals the same bit of `srr_msr_in`. This includes bit 14.
- R10: When `op_kind` is 2'b00 or 2'b11, all four valid flags are 0 and all four data outputs are 0.
- R11: `ctx_out` equals `ctx_in` for every value of `op_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | 00 none, 01 system call, 10 return, 11 reserved |
| cur_pc | input | 64 | Address of the current instruction |
| cur_msr | input | 64 | Current machine state word |
| srr_pc_in | input | 64 | Saved return address |
| srr_msr_in | input | 64 | Saved machine state word |
| ctx_in | input | CTX_W | Context tag from issue |
| next_pc | output | 64 | Next instruction address |
| next_pc_vld | output | 1 | next_pc is to be committed |
| srr_pc_out | output | 64 | New saved return address |
| srr_pc_vld | output | 1 | srr_pc_out is to be committed |
| srr_msr_out | output | 64 | New saved machine state word |
| srr_msr_vld | output | 1 | srr_msr_out is to be committed |
| msr_out | output | 64 | New machine state word |
| msr_vld | output | 1 | msr_out is to be committed |
| ctx_out | output | CTX_W | Context tag, passed through |

## Verification
The bench goes after the following corner cases:
- **Address wrap.** A current address of all ones must wrap to 3. A design that widened the adder or saturated it would produce a different value.
- **Machine-check enable.** Return cases pair a set or clear hypervisor bit with opposite machine-check enable values. A stage that always took the saved bit, or always kept the current one, would flip bit 12 in half of these cases.
- **Problem state.** Cases with the problem-state bit set and the three enable/relocate bits clear catch a missing OR, which would leave those bits at 0.
- **Masking and idle codes.** Saved words of all ones expose a wrong mask range as stray ones or zeros near bits 16 to 30. The reserved operation code exposes any valid flag or data that leaks out when no operation is active.

// File: rtl/trap_stage.sv
module trap_stage #(
  parameter int          CTX_W  = 2,
  parameter logic [63:0] SC_VEC = 64'hC00,
  parameter int          HV_B   = 60,
  parameter int          EE_B   = 15,
  parameter int          PR_B   = 14,
  parameter int          ME_B   = 12,
  parameter int          IR_B   = 5,
  parameter int          DR_B   = 4
) (
  input  logic [1:0]       op_kind,
  input  logic [63:0]      cur_pc,
  input  logic [63:0]      cur_msr,
  input  logic [63:0]      srr_pc_in,
  input  logic [63:0]      srr_msr_in,
  input  logic [CTX_W-1:0] ctx_in,
  output logic [63:0]      next_pc,
  output logic             next_pc_vld,
  output logic [63:0]      srr_pc_out,
  output logic             srr_pc_vld,
  output logic [63:0]      srr_msr_out,
  output logic             srr_msr_vld,
  output logic [63:0]      msr_out,
  output logic             msr_vld,
  output logic [CTX_W-1:0] ctx_out
);
  localparam logic [1:0]  OP_SC  = 2'b01;
  localparam logic [1:0]  OP_RET = 2'b10;
  localparam logic [63:0] SC_CLR = (64'h3F << 16) | (64'hF << 27);

  logic        is_sc, is_ret;
  logic [63:0] ret_msr;

  assign is_sc  = (op_kind == OP_SC);
  assign is_ret = (op_kind == OP_RET);

  always_comb begin
    ret_msr       = srr_msr_in;
    ret_msr[HV_B] = srr_msr_in[HV_B] & cur_msr[HV_B];
    ret_msr[EE_B] = srr_msr_in[EE_B] | srr_msr_in[PR_B];
    ret_msr[IR_B] = srr_msr_in[IR_B] | srr_msr_in[PR_B];
    ret_msr[DR_B] = srr_msr_in[DR_B] | srr_msr_in[PR_B];
    ret_msr[ME_B] = cur_msr[HV_B] ? srr_msr_in[ME_B] : cur_msr[ME_B];
  end

  assign next_pc     = is_sc ? SC_VEC : is_ret ? {srr_pc_in[63:2], 2'b00} : 64'd0;
  assign next_pc_vld = is_sc | is_ret;
  assign srr_pc_out  = is_sc ? cur_pc + 64'd4 : 64'd0;
  assign srr_pc_vld  = is_sc;
  assign srr_msr_out = is_sc ? (cur_msr & ~SC_CLR) : 64'd0;
  assign srr_msr_vld = is_sc;
  assign msr_out     = is_ret ? ret_msr : 64'd0;
  assign msr_vld     = is_ret;
  assign ctx_out     = ctx_in;
endmodule

// File: rtl/trap_stage_chk.sv
module trap_stage_chk #(
  parameter int CTX_W = 2
) (
  input logic [1:0]       op_kind,
  input logic [63:0]      cur_pc,
  input logic [63:0]      cur_msr,
  input logic [63:0]      srr_pc_in,
  input logic [63:0]      srr_msr_in,
  input logic [CTX_W-1:0] ctx_in,
  input logic [63:0]      next_pc,
  input logic             next_pc_vld,
  input logic [63:0]      srr_pc_out,
  input logic             srr_pc_vld,
  input logic [63:0]      srr_msr_out,
  input logic             srr_msr_vld,
  input logic [63:0]      msr_out,
  input logic             msr_vld,
  input logic [CTX_W-1:0] ctx_out
);
  localparam logic [63:0] KEEP = ~((64'h3F << 16) | (64'hF << 27));

  always_comb begin
    if (op_kind == 2'b01) begin
      p_sc_vector_r1: assert (next_pc_vld && next_pc == 64'hC00);
      p_sc_link_r2:   assert (srr_pc_vld && srr_pc_out - cur_pc == 64'd4);
      p_sc_mask_r3:   assert (srr_msr_vld && (srr_msr_out & ~KEEP) == 64'd0
                              && ((srr_msr_out ^ cur_msr) & KEEP) == 64'd0);
      p_sc_nomsr_r4:  assert (!msr_vld && msr_out == 64'd0);
    end
    if (op_kind == 2'b10) begin
      p_ret_pc_r5:    assert (next_pc_vld && msr_vld && !srr_pc_vld && !srr_msr_vld
                              && next_pc[1:0] == 2'b00 && next_pc[63:2] == srr_pc_in[63:2]);
      p_ret_hv_r6:    assert (msr_out[60] == (srr_msr_in[60] && cur_msr[60]));
      p_ret_ee_r7:    assert (msr_out[15] == (srr_msr_in[15] || srr_msr_in[14]));
      p_ret_me_r8:    assert (msr_out[12] == (cur_msr[60] ? srr_msr_in[12] : cur_msr[12]));
      p_ret_pr_r9:    assert (msr_out[14] == srr_msr_in[14]
                              && msr_out[59:16] == srr_msr_in[59:16]);
    end
    if (op_kind == 2'b00 || op_kind == 2'b11) begin
      p_idle_r10:     assert (!next_pc_vld && !srr_pc_vld && !srr_msr_vld && !msr_vld
                              && (next_pc | srr_pc_out | srr_msr_out | msr_out) == 64'd0);
    end
    p_ctx_r11: assert (ctx_out == ctx_in);
  end
endmodule

bind trap_stage trap_stage_chk #(.CTX_W(CTX_W)) u_chk (.*);

// File: tb/trap_stage_test.sv
module trap_stage_test;
  localparam int CTX_W = 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] pc, msr, spc, smsr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'b01, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0},
    '{2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_0000, 64'h0, 64'h0},
    '{2'b01, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8000_0000_0000_0001, 64'h5, 64'h9},
    '{2'b10, 64'h0, 64'h1000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'b10, 64'h0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1003, 64'hFFFF_FFFF_FFFF_EFFF},
    '{2'b10, 64'h0, 64'h1000_0000_0000_0000, 64'h2, 64'h0000_0000_0000_4000},
    '{2'b10, 64'h0, 64'h0000_0000_0000_1000, 64'h1, 64'h1000_0000_0000_0000},
    '{2'b10, 64'h0, 64'h1000_0000_0000_1000, 64'h8, 64'h0000_0000_0000_0000},
    '{2'b11, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'b00, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]       op_kind = 2'b00;
  logic [63:0]      cur_pc = '0, cur_msr = '0, srr_pc_in = '0, srr_msr_in = '0;
  logic [CTX_W-1:0] ctx_in = '0;
  logic [63:0]      next_pc, srr_pc_out, srr_msr_out, msr_out;
  logic             next_pc_vld, srr_pc_vld, srr_msr_vld, msr_vld;
  logic [CTX_W-1:0] ctx_out;

  trap_stage #(.CTX_W(CTX_W)) uut (.*);

  int compared = 0, mismatched = 0;
  logic done = 1'b0;

  logic [63:0] e_npc, e_spc, e_smsr, e_msr;
  logic        e_npcv, e_spcv, e_smsrv, e_msrv;

  task automatic model();
    e_npc = '0; e_spc = '0; e_smsr = '0; e_msr = '0;
    e_npcv = 0; e_spcv = 0; e_smsrv = 0; e_msrv = 0;
    if (op_kind == 2'b01) begin
      e_npc = 64'hC00; e_npcv = 1;
      e_spc = cur_pc + 64'd4; e_spcv = 1;
      for (int b = 0; b < 64; b++)
        e_smsr[b] = ((b >= 16 && b <= 21) || (b >= 27 && b <= 30)) ? 1'b0 : cur_msr[b];
      e_smsrv = 1;
    end else if (op_kind == 2'b10) begin
      e_npc = srr_pc_in; e_npc[0] = 0; e_npc[1] = 0; e_npcv = 1; e_msrv = 1;
      for (int b = 0; b < 64; b++) begin
        case (b)
          60:        e_msr[b] = srr_msr_in[b] & cur_msr[60];
          15, 5, 4:  e_msr[b] = srr_msr_in[b] | srr_msr_in[14];
          12:        e_msr[b] = cur_msr[60] ? srr_msr_in[12] : cur_msr[12];
          default:   e_msr[b] = srr_msr_in[b];
        endcase
      end
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    model();
    if (op_kind == 2'b01) begin
      chk("R1", {tag, " next_pc"}, {next_pc, next_pc_vld}, {e_npc, e_npcv});
      chk("R2", {tag, " srr_pc"}, {srr_pc_out, srr_pc_vld}, {e_spc, e_spcv});
      chk("R3", {tag, " srr_msr"}, {srr_msr_out, srr_msr_vld}, {e_smsr, e_smsrv});
      chk("R4", {tag, " msr"}, {msr_out, msr_vld}, {e_msr, e_msrv});
    end else if (op_kind == 2'b10) begin
      chk("R5", {tag, " next_pc"}, {next_pc, next_pc_vld}, {e_npc, e_npcv});
      chk("R5", {tag, " save outs"}, {srr_pc_out, srr_msr_out[0], srr_pc_vld, srr_msr_vld},
          {e_spc, 1'b0, 1'b0, 1'b0});
      chk("R5", {tag, " msr_vld"}, 64'(msr_vld), 64'(e_msrv));
      chk("R6", {tag, " hv"}, 64'(msr_out[60]), 64'(e_msr[60]));
      chk("R7", {tag, " ee/ir/dr"}, {msr_out[15], msr_out[5], msr_out[4]},
          {e_msr[15], e_msr[5], e_msr[4]});
      chk("R8", {tag, " me"}, 64'(msr_out[12]), 64'(e_msr[12]));
      chk("R9", {tag, " msr full"}, msr_out, e_msr);
    end else begin
      chk("R10", {tag, " data"}, next_pc | srr_pc_out | srr_msr_out | msr_out, 64'd0);
      chk("R10", {tag, " flags"}, {next_pc_vld, srr_pc_vld, srr_msr_vld, msr_vld}, 64'd0);
    end
    chk("R11", {tag, " ctx"}, 64'(ctx_out), 64'(ctx_in));
  endtask

  task automatic apply(logic [1:0] op, logic [63:0] pc, msr, spc, smsr, logic [CTX_W-1:0] c);
    @(posedge clk);
    op_kind = op; cur_pc = pc; cur_msr = msr; srr_pc_in = spc; srr_msr_in = smsr; ctx_in = c;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check_all("idle start");
    for (int i = 0; i < 10; i++) begin
      apply(VECS[i].op, VECS[i].pc, VECS[i].msr, VECS[i].spc, VECS[i].smsr, CTX_W'(i));
      check_all($sformatf("vec%0d", i));
    end
    for (int i = 0; i < 400; i++) begin
      apply(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom}, CTX_W'($urandom));
      check_all($sformatf("rnd%0d", i));
    end
    // R8 corner: hv set, me differs between current and saved
    apply(2'b10, 64'h0, 64'h1000_0000_0000_0000, 64'h0, 64'h0000_0000_0000_1000, '1);
    chk("R8", "me from saved when hv", 64'(msr_out[12]), 64'd1);
    // R8 corner: hv clear, current me kept
    apply(2'b10, 64'h0, 64'h0000_0000_0000_1000, 64'h0, 64'h0, '0);
    chk("R8", "me kept when not hv", 64'(msr_out[12]), 64'd1);
    // R7 corner: problem state forces enables
    apply(2'b10, 64'h0, 64'h0, 64'h0, 64'h0000_0000_0000_4000, '0);
    chk("R7", "pr forces ee/ir/dr", msr_out, 64'h0000_0000_0000_C030);
    // R2 corner: wrap of return address
    apply(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, '0);
    chk("R2", "wrap", srr_pc_out, 64'h3);
    // R3 corner: exact mask
    apply(2'b01, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, '0);
    chk("R3", "mask all ones", srr_msr_out, 64'hFFFF_FFFF_87C0_FFFF);
    // R10 corner: reserved op with all inputs high
    apply(2'b11, '1, '1, '1, '1, '1);
    chk("R10", "reserved quiet", {next_pc_vld, srr_pc_vld, srr_msr_vld, msr_vld}, 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule